// File: doc/BRIEF.md
# Calendar Clock with Alarm Match

This block keeps a time-of-year calendar (seconds, minutes, hours, day of month, month and a full 32-bit year). It advances from a sub-second tick that arrives sixteen times per second. Software sets and reads the time through a small 32-bit register interface. A control word gates both the counting and the alarm interrupt.

A separate alarm word holds a target second, minute, hour, day, month and the low six bits of a year. Its fields are packed differently from the time word. The calendar is compared with the alarm each time it advances. When a tick brings the time to exactly the alarm fields with the sub-second count at zero, and the calendar enable is set, the block emits a one-cycle interrupt pulse.

The register interface has no back-pressure. Every write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address, so it is valid in the same cycle. Only whole 32-bit words are transferred.

Top module: `toy_calendar`

## Requirements
- R1: After reset the time word reads month 1, day 1, 00:00:00, sub-second 0 (0x04200000). The year reads 0, the control word reads 0, and the interrupt is low.
- R2: Time word layout: month in bits 31:26 (January = 1), day in 25:21, hour in 20:16, minute in 15:10, second in 9:4, sub-second in 3:0. It is read at offset 0x2C. A write to offset 0x24 loads all the packed fields at once and clears the sub-second count. A write takes priority over a tick in the same cycle.
- R3: While control bit 11 is set, each tick increments the sub-second count. On the tick that wraps the sub-second count from 15 to 0, the second advances.
- R4: While control bit 11 is clear, ticks leave the time and the year unchanged.
- R5: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day.
- R6: The day wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R7: Month 12 wraps to month 1 and increments the year. The year is written at offset 0x28 and read at offset 0x30 as a full 32-bit value. Writing the year leaves the packed time fields unchanged.
- R8: Alarm word at offset 0x34: year-low in bits 31:26, month in 25:22, day in 21:17, hour in 16:12, minute in 11:6, second in 5:0. The interrupt pulses high for exactly one cycle, in the cycle after the clock edge of an enabled tick. That tick must bring the time to equal every alarm field with the sub-second count at 0.
- R9: The alarm year field is compared only with the low 6 bits of the current year. A mismatch in any field gives no pulse.
- R10: Offsets 0x34, 0x38, 0x3C and 0x40 read back the last value written there. Control bit 13 is only stored. Reads of any other offset, including the write-only offsets 0x24 and 0x28, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_sub | input | 1 | One-cycle pulse every 1/16 second |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
A wrong carry or month-length decision stays hidden until the sixteenth tick, at the second boundary. It then appears in the time word at 0x2C, or in the year at 0x30 for a December wrap. The bench therefore loads times one second before each boundary and reads the result right after the wrapping tick. A faulty alarm compare or gate shows on alarm_irq in the cycle after the matching tick, as a missing pulse, a pulse on the wrong tick or a pulse longer than one cycle. The bench counts pulses and records the tick on which each one occurs.

// File: rtl/toyc_pkg.sv
package toyc_pkg;
  localparam logic [7:0] OFS_TIME_WR  = 8'h24;
  localparam logic [7:0] OFS_YEAR_WR  = 8'h28;
  localparam logic [7:0] OFS_TIME_RD  = 8'h2C;
  localparam logic [7:0] OFS_YEAR_RD  = 8'h30;
  localparam logic [7:0] OFS_ALARM0   = 8'h34;
  localparam logic [7:0] OFS_CTRL     = 8'h40;

  typedef struct packed {
    logic [5:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  function automatic logic [4:0] month_len(input logic [5:0] mon, input logic leap);
    case (mon)
      6'd4, 6'd6, 6'd9, 6'd11: month_len = 5'd30;
      6'd2:                    month_len = leap ? 5'd29 : 5'd28;
      default:                 month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/toyc_calendar.sv
module toyc_calendar
  import toyc_pkg::*;
#(
  parameter int SUB_W  = 4,
  parameter int YEAR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load_time,
  input  logic              load_year,
  input  logic [31:0]       wdata,
  output cal_t              cal_q,
  output logic [SUB_W-1:0]  sub_q,
  output logic [YEAR_W-1:0] year_q,
  output cal_t              cal_nxt,
  output logic [SUB_W-1:0]  sub_nxt,
  output logic [YEAR_W-1:0] year_nxt
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  logic c_sec, c_min, c_hour, c_day, c_mon;

  always_comb begin
    cal_nxt  = cal_q;
    year_nxt = year_q;
    sub_nxt  = sub_q + 1'b1;
    c_sec    = (sub_q == SUB_MAX);
    c_min    = c_sec  && (cal_q.sec  >= 6'd59);
    c_hour   = c_min  && (cal_q.min  >= 6'd59);
    c_day    = c_hour && (cal_q.hour >= 5'd23);
    c_mon    = c_day  && (cal_q.day  >= month_len(cal_q.mon, year_q[1:0] == 2'b00));
    if (c_sec)  cal_nxt.sec  = c_min  ? 6'd0 : cal_q.sec + 6'd1;
    if (c_min)  cal_nxt.min  = c_hour ? 6'd0 : cal_q.min + 6'd1;
    if (c_hour) cal_nxt.hour = c_day  ? 5'd0 : cal_q.hour + 5'd1;
    if (c_day)  cal_nxt.day  = c_mon  ? 5'd1 : cal_q.day + 5'd1;
    if (c_mon) begin
      if (cal_q.mon >= 6'd12) begin
        cal_nxt.mon = 6'd1;
        year_nxt    = year_q + 1'b1;
      end else begin
        cal_nxt.mon = cal_q.mon + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= '{mon: 6'd1, day: 5'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};
      sub_q  <= '0;
      year_q <= '0;
    end else if (load_time || load_year) begin
      if (load_time) begin
        cal_q <= '{mon: wdata[31:26], day: wdata[25:21], hour: wdata[20:16],
                   min: wdata[15:10], sec: wdata[9:4]};
        sub_q <= '0;
      end
      if (load_year) year_q <= wdata[YEAR_W-1:0];
    end else if (adv) begin
      cal_q  <= cal_nxt;
      sub_q  <= sub_nxt;
      year_q <= year_nxt;
    end
  end
endmodule

// File: rtl/toyc_alarm.sv
module toyc_alarm
  import toyc_pkg::*;
#(
  parameter int SUB_W = 4,
  parameter int YLO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  cal_t             cal_nxt,
  input  logic [SUB_W-1:0] sub_nxt,
  input  logic [YLO_W-1:0] year_lo_nxt,
  input  logic [31:0]      alarm_word,
  output logic             irq
);
  logic hit;

  always_comb begin
    hit = (sub_nxt == '0)
       && (year_lo_nxt  == alarm_word[31:26])
       && (cal_nxt.mon  == {2'b00, alarm_word[25:22]})
       && (cal_nxt.day  == alarm_word[21:17])
       && (cal_nxt.hour == alarm_word[16:12])
       && (cal_nxt.min  == alarm_word[11:6])
       && (cal_nxt.sec  == alarm_word[5:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= adv && hit;
  end
endmodule

// File: rtl/toyc_regs.sv
module toyc_regs
  import toyc_pkg::*;
#(
  parameter int N_ALARM = 3,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic [31:0]       time_word,
  input  logic [31:0]       year_word,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       alarm0_q,
  output logic [31:0]       rdata
);
  logic [31:0] alarm_q [N_ALARM];

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFS_ALARM0) + ADDR_W'(4 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 alarm_q[g] <= '0;
      else if (we && addr == OFS) alarm_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 ctrl_q <= '0;
    else if (we && addr == ADDR_W'(OFS_CTRL))   ctrl_q <= wdata;
  end

  assign alarm0_q = alarm_q[0];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_TIME_RD)) rdata = time_word;
    if (addr == ADDR_W'(OFS_YEAR_RD)) rdata = year_word;
    if (addr == ADDR_W'(OFS_CTRL))    rdata = ctrl_q;
    for (int i = 0; i < N_ALARM; i++)
      if (addr == ADDR_W'(OFS_ALARM0) + ADDR_W'(4 * i)) rdata = alarm_q[i];
  end
endmodule

// File: rtl/toy_calendar.sv
module toy_calendar
  import toyc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SUB_W   = 4,
  parameter int EN_BIT  = 11,
  parameter int N_ALARM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_sub,
  output logic              alarm_irq
);
  localparam int YLO_W = 6;

  logic [31:0]      ctrl_q, alarm0_q, time_word, year_q, year_nxt;
  cal_t             cal_q, cal_nxt;
  logic [SUB_W-1:0] sub_q, sub_nxt;
  logic             load_time, load_year, cal_en, adv;

  assign load_time = bus_we && bus_addr == ADDR_W'(OFS_TIME_WR);
  assign load_year = bus_we && bus_addr == ADDR_W'(OFS_YEAR_WR);
  assign cal_en    = ctrl_q[EN_BIT];
  assign adv       = tick_sub && cal_en && !load_time && !load_year;
  assign time_word = {cal_q.mon, cal_q.day, cal_q.hour, cal_q.min, cal_q.sec, sub_q};

  toyc_calendar #(.SUB_W(SUB_W), .YEAR_W(32)) u_cal (
    .clk, .rst_n, .adv, .load_time, .load_year, .wdata(bus_wdata),
    .cal_q, .sub_q, .year_q, .cal_nxt, .sub_nxt, .year_nxt
  );

  toyc_alarm #(.SUB_W(SUB_W), .YLO_W(YLO_W)) u_alarm (
    .clk, .rst_n, .adv, .cal_nxt, .sub_nxt, .year_lo_nxt(year_nxt[YLO_W-1:0]),
    .alarm_word(alarm0_q), .irq(alarm_irq)
  );

  toyc_regs #(.N_ALARM(N_ALARM), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .time_word, .year_word(year_q), .ctrl_q, .alarm0_q, .rdata(bus_rdata)
  );
endmodule

// File: rtl/toyc_checker.sv
module toyc_checker
  import toyc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_rdata,
  input logic        tick_sub,
  input logic        alarm_irq,
  input logic        cal_en,
  input logic [31:0] time_word,
  input logic [31:0] year_q
);
  logic mapped;
  assign mapped = bus_addr inside {OFS_TIME_RD, OFS_YEAR_RD, OFS_ALARM0,
                                   8'h38, 8'h3C, OFS_CTRL};

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |=> !alarm_irq);                                          // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(tick_sub && cal_en));                           // R8
  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sub && cal_en && !bus_we) |=> time_word[3:0] == $past(time_word[3:0]) + 4'd1); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_sub && cal_en) && !bus_we) |=> $stable(time_word) && $stable(year_q)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'd0);                                    // R10
endmodule

bind toy_calendar toyc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .tick_sub(tick_sub), .alarm_irq(alarm_irq),
  .cal_en(cal_en), .time_word(time_word), .year_q(year_q)
);

// File: tb/toy_calendar_tb_top.sv
module toy_calendar_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        tick_sub = 0;
  logic        alarm_irq;
  int          errors = 0, checks = 0;
  int          pulses = 0, last_pulse_tick = -1, tick_no = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  toy_calendar dut_i (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
                      .tick_sub, .alarm_irq);

  function automatic logic [31:0] tw(int mo, int d, int h, int mi, int s, int sub);
    return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) | (32'(mi) << 10) |
           (32'(s) << 4) | 32'(sub);
  endfunction
  function automatic logic [31:0] aw(int y, int mo, int d, int h, int mi, int s);
    return (32'(y & 63) << 26) | (32'(mo) << 22) | (32'(d) << 17) | (32'(h) << 12) |
           (32'(mi) << 6) | 32'(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_sub = 1;
      @(negedge clk); tick_sub = 0; tick_no++;
      if (alarm_irq) begin pulses++; last_pulse_tick = tick_no; end
      @(negedge clk);
      if (alarm_irq) begin pulses++; last_pulse_tick = -99; end
    end
  endtask
  task automatic set_time(logic [31:0] t, logic [31:0] y);
    wr(8'h28, y); wr(8'h24, t);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h2C, d); check("R1 time", d, 32'h0420_0000);
    rd(8'h30, d); check("R1 year", d, 0);
    rd(8'h40, d); check("R1 ctrl", d, 0);
    check("R1 irq", 32'(alarm_irq), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h40, 32'h0000_2000); rd(8'h40, d); check("R10 ctrl bit13", d, 32'h2000);
    wr(8'h38, 32'hA5A5_1234); rd(8'h38, d); check("R10 alarm1", d, 32'hA5A5_1234);
    wr(8'h3C, 32'h0BAD_F00D); rd(8'h3C, d); check("R10 alarm2", d, 32'h0BAD_F00D);
    rd(8'h24, d); check("R10 wr-only 0x24", d, 0);
    rd(8'h28, d); check("R10 wr-only 0x28", d, 0);
    rd(8'h50, d); check("R10 unmapped", d, 0);
  endtask

  task automatic t_load_hold;
    logic [31:0] d;
    set_time(tw(7, 14, 9, 30, 15, 0), 32'hDEAD_0123);
    rd(8'h2C, d); check("R2 load", d, tw(7, 14, 9, 30, 15, 0));
    rd(8'h30, d); check("R7 year full", d, 32'hDEAD_0123);
    tick(5);
    rd(8'h2C, d); check("R4 no advance", d, tw(7, 14, 9, 30, 15, 0));
    wr(8'h28, 32'd2030);
    rd(8'h2C, d); check("R7 year write keeps time", d, tw(7, 14, 9, 30, 15, 0));
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(8'h40, 32'h0000_0800);
    set_time(tw(3, 3, 0, 0, 59, 0), 2025);
    tick(3);
    rd(8'h2C, d); check("R3 sub count", d, tw(3, 3, 0, 0, 59, 3));
    wr(8'h24, tw(3, 3, 0, 0, 59, 0));
    rd(8'h2C, d); check("R2 load clears sub", d, tw(3, 3, 0, 0, 59, 0));
    tick(16);
    rd(8'h2C, d); check("R5 minute carry", d, tw(3, 3, 0, 1, 0, 0));
    wr(8'h24, tw(3, 3, 10, 59, 59, 0)); tick(16);
    rd(8'h2C, d); check("R5 hour carry", d, tw(3, 3, 11, 0, 0, 0));
  endtask

  task automatic t_calendar;
    logic [31:0] d;
    set_time(tw(12, 31, 23, 59, 59, 0), 2023); tick(16);
    rd(8'h2C, d); check("R7 new year time", d, tw(1, 1, 0, 0, 0, 0));
    rd(8'h30, d); check("R7 new year", d, 2024);
    set_time(tw(2, 28, 23, 59, 59, 0), 2024); tick(16);
    rd(8'h2C, d); check("R6 leap feb 29", d, tw(2, 29, 0, 0, 0, 0));
    wr(8'h24, tw(2, 29, 23, 59, 59, 0)); tick(16);
    rd(8'h2C, d); check("R6 leap mar 1", d, tw(3, 1, 0, 0, 0, 0));
    set_time(tw(2, 28, 23, 59, 59, 0), 2023); tick(16);
    rd(8'h2C, d); check("R6 common mar 1", d, tw(3, 1, 0, 0, 0, 0));
    wr(8'h24, tw(4, 30, 23, 59, 59, 0)); tick(16);
    rd(8'h2C, d); check("R6 apr 30", d, tw(5, 1, 0, 0, 0, 0));
    wr(8'h24, tw(5, 30, 23, 59, 59, 0)); tick(16);
    rd(8'h2C, d); check("R6 may 31", d, tw(5, 31, 0, 0, 0, 0));
  endtask

  task automatic t_alarm;
    set_time(tw(1, 5, 10, 20, 30, 0), 2024);
    wr(8'h34, aw(2024, 1, 5, 10, 20, 31));
    pulses = 0; tick_no = 0; last_pulse_tick = -1;
    tick(32);
    check("R8 pulse count", pulses, 1);
    check("R8 pulse tick", last_pulse_tick, 16);
    set_time(tw(1, 5, 10, 20, 30, 0), 2024 + 64);
    pulses = 0; tick_no = 0; last_pulse_tick = -1;
    tick(20);
    check("R9 low year bits only", pulses, 1);
    set_time(tw(1, 5, 10, 20, 30, 0), 2025);
    pulses = 0; tick(20);
    check("R9 year mismatch", pulses, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_regs; t_load_hold; t_count; t_calendar; t_alarm;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule